// File: doc/BRIEF.md
# DMA Bus-Master Handshake Front End

This block sits between an internal DMA requester and a shared, multiplexed 16-bit address/data bus. The requester presents a transfer (address, word-or-byte size) and holds it valid. The block then asks for bus ownership, waits for the grant, runs a one-clock address phase with an address strobe, and holds the bus for a fixed-length data phase. After that it returns a done pulse and releases the bus. The data path itself is not part of the block. A counter stands in for the data phase.

Two configuration inputs choose the variant. `cfg_pinset` picks the pin set. With 0, the two lane lines carry a two-bit byte mask. With 1, lane line 0 carries a byte/word flag, lane line 1 becomes a grant daisy-chain output, and a misaligned word is rejected. `cfg_strb_inv` picks the strobe polarity. Lane and strobe lines have output enables and float whenever the block does not own the bus. Configuration is expected to stay static while a transfer is in flight.

Top module: `dma_master_hs`

## Requirements
- R1: While reset is held and after its release with no request, `bus_req_n` is 1, `lane0_oe`, `strb_oe`, `addr_oe`, `xfer_done` and `xfer_err` are 0, and with `cfg_pinset`=0 `lane1_oe` is 0.
- R2: A request is raised (`bus_req_n` falls) on the clock edge that sees `xfer_valid` with `bus_gnt_n` high. While `bus_gnt_n` is low and the block is idle, no request is raised. With `cfg_pinset`=1 the request line must also have been high on the previous clock.
- R3: Once low, `bus_req_n` stays low through the address phase and every data-phase cycle. It returns high in the clock after the last data cycle.
- R4: The address phase lasts exactly one clock. It starts on the edge after `bus_gnt_n` is seen low while requesting. During it `addr_o` carries the latched address with `addr_oe`=1. Outside it `addr_oe` is 0.
- R5: With `cfg_strb_inv`=0 the strobe is 1 in the address phase and 0 in the data phase. With `cfg_strb_inv`=1 both levels are inverted.
- R6: The data phase lasts DATA_CYC clocks. `xfer_done` is 1 for exactly its last clock.
- R7: With `cfg_pinset`=0 the lane code {lane1_o,lane0_o} is 00 for a word, 01 for a byte at an odd address (upper byte, bits 15:8) and 10 for a byte at an even address (lower byte, bits 7:0). Code 11 means no transfer and is never issued.
- R8: With `cfg_pinset`=1, `lane0_o` is 1 for a byte and 0 for a word. The lane is selected by address bit 0 on `addr_o` (0 lower, 1 upper). A word request with address bit 0 set raises `xfer_err` for one clock per clock held and raises no request. With `cfg_pinset`=0 the same request proceeds as a word.
- R9: `lane0_oe` and `strb_oe` are 1 only during the address and data phases. `lane1_oe` follows the same rule with `cfg_pinset`=0 and is always 1 with `cfg_pinset`=1.
- R10: With `cfg_pinset`=1, `lane1_o` is the daisy-chain grant. It is 0 while `bus_gnt_n` is low and the block is idle (not requesting). It is 1 whenever the block is requesting or owns the bus.
- R11: After release, no new request is raised until `bus_gnt_n` has returned high, even with `xfer_valid` already held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pinset | input | 1 | Pin-set / request-style select |
| cfg_strb_inv | input | 1 | Address strobe polarity select |
| xfer_valid | input | 1 | Transfer request from the internal requester |
| xfer_addr | input | AW | Transfer address |
| xfer_byte | input | 1 | 1 = byte transfer, 0 = word |
| xfer_done | output | 1 | Pulse in the last data-phase clock |
| xfer_err | output | 1 | Misaligned-word rejection pulse |
| bus_req_n | output | 1 | Bus request, active low |
| bus_gnt_n | input | 1 | Bus grant, active low |
| lane0_o | output | 1 | Lane line 0 value |
| lane0_oe | output | 1 | Lane line 0 output enable |
| lane1_o | output | 1 | Lane line 1 value (mask bit or daisy-chain grant) |
| lane1_oe | output | 1 | Lane line 1 output enable |
| strb_o | output | 1 | Address strobe value |
| strb_oe | output | 1 | Address strobe output enable |
| addr_o | output | AW | Address driven in the address phase |
| addr_oe | output | 1 | Address output enable |

## Verification
The daisy-chain decision and the request decision both read the grant input in the same clock. A requester that turns valid in the very clock another master is granted must neither request nor block the chain. The bench provokes this by driving `xfer_valid` and a low `bus_gnt_n` on the same edge with `cfg_pinset`=1. It then checks that `bus_req_n` stays high and `lane1_o` passes the grant low. After the grant returns high, it checks that the request falls one clock later. A second overlap comes at release: the bench holds the grant low while re-presenting a request and confirms that the stale grant starts no new transfer.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_ADDR = 3'd2,
    ST_DATA = 3'd3,
    ST_REL  = 3'd4
  } hs_state_e;

  // word with odd address cannot be expressed in pin-set 1
  function automatic logic word_misaligned(input logic pinset,
                                           input logic is_byte,
                                           input logic a0);
    return pinset & ~is_byte & a0;
  endfunction

  // returns {lane1, lane0}; in pin-set 1 lane1 is overridden by the chain
  function automatic logic [1:0] lane_code(input logic pinset,
                                           input logic is_byte,
                                           input logic a0);
    logic [1:0] code;
    if (!pinset) begin
      if (!is_byte)  code = 2'b00;
      else if (a0)   code = 2'b01;
      else           code = 2'b10;
    end else begin
      code = {1'b1, is_byte};
    end
    return code;
  endfunction

  // strobe level: asserted level in address phase, idle level in data phase
  function automatic logic strobe_level(input logic inv, input logic addr_ph);
    return addr_ph ^ inv;
  endfunction

endpackage

// File: rtl/dma_hs_seq.sv
module dma_hs_seq
  import dma_hs_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DATA_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pinset,
  input  logic          xfer_valid,
  input  logic [AW-1:0] xfer_addr,
  input  logic          xfer_byte,
  input  logic          bus_gnt_n,
  output logic          req_n,
  output logic          idle,
  output logic          addr_ph,
  output logic          data_ph,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] lat_addr,
  output logic          lat_byte
);

  localparam int CW   = (DATA_CYC > 1) ? $clog2(DATA_CYC) : 1;
  localparam int LAST = DATA_CYC - 1;

  hs_state_e       state_q, state_d;
  logic [CW-1:0]   cnt_q;
  logic            req_prev_q;
  logic            err_q;
  logic            bad_req;
  logic            start_req;
  logic            last_beat;

  assign bad_req   = word_misaligned(pinset, xfer_byte, xfer_addr[0]);
  assign last_beat = (state_q == ST_DATA) && (cnt_q == CW'(LAST));
  // pin-set 1 additionally needs the request line to have been high
  assign start_req = xfer_valid && !bad_req && bus_gnt_n &&
                     (pinset ? req_prev_q : 1'b1);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_req)  state_d = ST_REQ;
      ST_REQ:  if (!bus_gnt_n) state_d = ST_ADDR;
      ST_ADDR:                 state_d = ST_DATA;
      ST_DATA: if (last_beat)  state_d = ST_REL;
      ST_REL:  if (bus_gnt_n)  state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      req_prev_q <= 1'b1;
      err_q      <= 1'b0;
      lat_addr   <= '0;
      lat_byte   <= 1'b0;
    end else begin
      state_q    <= state_d;
      req_prev_q <= req_n;
      err_q      <= (state_q == ST_IDLE) && xfer_valid && bad_req;
      if (state_q == ST_IDLE && start_req) begin
        lat_addr <= xfer_addr;
        lat_byte <= xfer_byte;
      end
      if (state_q == ST_DATA) cnt_q <= cnt_q + CW'(1);
      else                    cnt_q <= '0;
    end
  end

  assign req_n   = !(state_q == ST_REQ || state_q == ST_ADDR || state_q == ST_DATA);
  assign idle    = (state_q == ST_IDLE);
  assign addr_ph = (state_q == ST_ADDR);
  assign data_ph = (state_q == ST_DATA);
  assign done    = last_beat;
  assign err     = err_q;

  p_req_fall_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_n) |-> $past(bus_gnt_n));

  p_addr_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ph |=> (data_ph && !addr_ph));

  p_done_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_n));

  p_err_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> req_n);

  p_data_holds_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ph && !done) |=> (data_ph && !req_n));

endmodule

// File: rtl/dma_hs_pins.sv
module dma_hs_pins
  import dma_hs_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pinset,
  input  logic          strb_inv,
  input  logic          idle,
  input  logic          addr_ph,
  input  logic          data_ph,
  input  logic          bus_gnt_n,
  input  logic [AW-1:0] lat_addr,
  input  logic          lat_byte,
  output logic          lane0_o,
  output logic          lane0_oe,
  output logic          lane1_o,
  output logic          lane1_oe,
  output logic          strb_o,
  output logic          strb_oe,
  output logic [AW-1:0] addr_o,
  output logic          addr_oe
);

  logic       own_bus;
  logic [1:0] code;
  logic       chain_n;

  assign own_bus = addr_ph | data_ph;
  assign code    = lane_code(pinset, lat_byte, lat_addr[0]);
  // pass the grant down the chain only when not wanting the bus
  assign chain_n = !(!bus_gnt_n && idle);

  assign lane0_o  = own_bus ? code[0] : 1'b0;
  assign lane0_oe = own_bus;
  assign lane1_o  = pinset ? chain_n : (own_bus ? code[1] : 1'b0);
  assign lane1_oe = pinset | own_bus;
  assign strb_o   = own_bus ? strobe_level(strb_inv, addr_ph) : 1'b0;
  assign strb_oe  = own_bus;
  assign addr_o   = addr_ph ? lat_addr : '0;
  assign addr_oe  = addr_ph;

  p_chain_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pinset && !idle) |-> lane1_o);

  p_no_code11_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pinset && own_bus) |-> !(lane1_o && lane0_o));

endmodule

// File: rtl/dma_master_hs.sv
module dma_master_hs #(
  parameter int AW       = 16,
  parameter int DATA_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_pinset,
  input  logic          cfg_strb_inv,
  input  logic          xfer_valid,
  input  logic [AW-1:0] xfer_addr,
  input  logic          xfer_byte,
  output logic          xfer_done,
  output logic          xfer_err,
  output logic          bus_req_n,
  input  logic          bus_gnt_n,
  output logic          lane0_o,
  output logic          lane0_oe,
  output logic          lane1_o,
  output logic          lane1_oe,
  output logic          strb_o,
  output logic          strb_oe,
  output logic [AW-1:0] addr_o,
  output logic          addr_oe
);

  logic          idle, addr_ph, data_ph;
  logic [AW-1:0] lat_addr;
  logic          lat_byte;

  dma_hs_seq #(.AW(AW), .DATA_CYC(DATA_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pinset     (cfg_pinset),
    .xfer_valid (xfer_valid),
    .xfer_addr  (xfer_addr),
    .xfer_byte  (xfer_byte),
    .bus_gnt_n  (bus_gnt_n),
    .req_n      (bus_req_n),
    .idle       (idle),
    .addr_ph    (addr_ph),
    .data_ph    (data_ph),
    .done       (xfer_done),
    .err        (xfer_err),
    .lat_addr   (lat_addr),
    .lat_byte   (lat_byte)
  );

  dma_hs_pins #(.AW(AW)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .pinset    (cfg_pinset),
    .strb_inv  (cfg_strb_inv),
    .idle      (idle),
    .addr_ph   (addr_ph),
    .data_ph   (data_ph),
    .bus_gnt_n (bus_gnt_n),
    .lat_addr  (lat_addr),
    .lat_byte  (lat_byte),
    .lane0_o   (lane0_o),
    .lane0_oe  (lane0_oe),
    .lane1_o   (lane1_o),
    .lane1_oe  (lane1_oe),
    .strb_o    (strb_o),
    .strb_oe   (strb_oe),
    .addr_o    (addr_o),
    .addr_oe   (addr_oe)
  );

  p_strb_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb_oe |-> !bus_req_n);

  p_lane_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lane0_oe |-> (!bus_req_n && !xfer_err));

endmodule

// File: tb/test_dma_master_hs.sv
`timescale 1ns/1ps
module test_dma_master_hs;

  localparam int AW = 16;
  localparam int DC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pinset = 1'b0, cfg_strb_inv = 1'b0;
  logic xfer_valid = 1'b0, xfer_byte = 1'b0;
  logic [AW-1:0] xfer_addr = '0;
  logic bus_gnt_n = 1'b1;
  logic xfer_done, xfer_err, bus_req_n;
  logic lane0_o, lane0_oe, lane1_o, lane1_oe, strb_o, strb_oe, addr_oe;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dma_master_hs #(.AW(AW), .DATA_CYC(DC)) i_dma_master_hs (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // finish a transfer whose request is already low
  task automatic finish_xfer();
    bus_gnt_n = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (xfer_done) break;
    end
    xfer_valid = 1'b0;
    @(negedge clk);
    bus_gnt_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "req_n", bus_req_n, 1);
    chk("R1", "lane0_oe", lane0_oe, 0);
    chk("R1", "lane1_oe", lane1_oe, 0);
    chk("R1", "strb_oe", strb_oe, 0);
    chk("R1", "addr_oe", addr_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req_n idle", bus_req_n, 1);
    chk("R1", "done/err", {xfer_done, xfer_err}, 0);
  endtask

  // full transfer with every phase checked
  task automatic t_xfer(input logic ps, input logic inv,
                        input logic [AW-1:0] a, input logic b);
    logic [1:0] exp_code;
    if (!ps) exp_code = !b ? 2'b00 : (a[0] ? 2'b01 : 2'b10);
    else     exp_code = {1'b1, b};
    cfg_pinset = ps; cfg_strb_inv = inv;
    xfer_addr = a; xfer_byte = b; xfer_valid = 1'b1;
    @(negedge clk);
    chk("R2", "req raised", bus_req_n, 0);
    chk("R9", "strb_oe before grant", strb_oe, 0);
    chk("R9", "lane0_oe before grant", lane0_oe, 0);
    if (ps) chk("R10", "chain while requesting", lane1_o, 1);
    bus_gnt_n = 1'b0;
    @(negedge clk);
    chk("R4", "addr_oe", addr_oe, 1);
    chk("R4", "addr", addr_o, a);
    chk("R5", "strobe addr phase", strb_o, inv ? 0 : 1);
    chk("R9", "strb_oe", strb_oe, 1);
    chk("R9", "lane1_oe", lane1_oe, 1);
    chk(ps ? "R8" : "R7", "lane code", {lane1_o, lane0_o}, exp_code);
    chk("R3", "req in addr", bus_req_n, 0);
    for (int i = 0; i < DC; i++) begin
      @(negedge clk);
      chk("R4", "addr_oe data", addr_oe, 0);
      chk("R5", "strobe data phase", strb_o, inv ? 1 : 0);
      chk("R3", "req in data", bus_req_n, 0);
      chk("R6", "done", xfer_done, (i == DC - 1) ? 1 : 0);
      chk(ps ? "R8" : "R7", "lane code data", {lane1_o, lane0_o}, exp_code);
    end
    xfer_valid = 1'b0;
    @(negedge clk);
    chk("R3", "req released", bus_req_n, 1);
    chk("R6", "done gone", xfer_done, 0);
    chk("R9", "strb_oe released", strb_oe, 0);
    chk("R9", "lane0_oe released", lane0_oe, 0);
    chk("R9", "lane1_oe released", lane1_oe, ps ? 1 : 0);
    bus_gnt_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_misaligned();
    cfg_pinset = 1'b1; xfer_addr = 16'h1235; xfer_byte = 1'b0; xfer_valid = 1'b1;
    @(negedge clk);
    chk("R8", "err", xfer_err, 1);
    chk("R8", "no req", bus_req_n, 1);
    xfer_valid = 1'b0;
    @(negedge clk);
    chk("R8", "err single", xfer_err, 0);
    chk("R8", "still no req", bus_req_n, 1);
    cfg_pinset = 1'b0; xfer_valid = 1'b1;
    @(negedge clk);
    chk("R8", "pinset0 no err", xfer_err, 0);
    chk("R8", "pinset0 word proceeds", bus_req_n, 0);
    finish_xfer();
  endtask

  task automatic t_foreign_grant();
    cfg_pinset = 1'b1; xfer_addr = 16'h0040; xfer_byte = 1'b1;
    bus_gnt_n = 1'b0; xfer_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2", "no req under foreign grant", bus_req_n, 1);
      chk("R10", "chain passes grant", lane1_o, 0);
      chk("R9", "lane0 floats", lane0_oe, 0);
    end
    bus_gnt_n = 1'b1;
    @(negedge clk);
    chk("R10", "chain high after grant gone", lane1_o, 1);
    chk("R2", "req after grant gone", bus_req_n, 0);
    finish_xfer();
  endtask

  task automatic t_stale_grant();
    cfg_pinset = 1'b0; xfer_addr = 16'h0100; xfer_byte = 1'b0; xfer_valid = 1'b1;
    @(negedge clk);
    bus_gnt_n = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (xfer_done) break;
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11", "no req on stale grant", bus_req_n, 1);
    end
    bus_gnt_n = 1'b1;
    @(negedge clk);
    chk("R11", "one clock to idle", bus_req_n, 1);
    @(negedge clk);
    chk("R11", "req after grant high", bus_req_n, 0);
    finish_xfer();
  endtask

  initial begin
    t_reset();
    t_xfer(1'b0, 1'b0, 16'hA5A4, 1'b0);
    t_xfer(1'b0, 1'b0, 16'h0011, 1'b1);
    t_xfer(1'b0, 1'b1, 16'h0010, 1'b1);
    t_xfer(1'b1, 1'b1, 16'h2223, 1'b1);
    t_xfer(1'b1, 1'b0, 16'h3332, 1'b0);
    t_misaligned();
    t_foreign_grant();
    t_stale_grant();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule